// File: doc/BRIEF.md
# Mask-Write Register File

An eight-entry register file for a small accumulator processor. A single write bus is built by a four-way source selector: forced zero, immediate data from the controller, the arithmetic unit's result, or data read from memory. Every entry whose bit is set in a one-hot write mask captures that bus on the clock edge. An entry whose bit is clear keeps its value. Several bits may be set at once, and then all selected entries load the same value together.

One combinational read port returns the entry named by a binary index. A write shows up on that port in the cycle after the write edge. Entry 0 is the only one that may be loaded straight from an immediate or from memory. Writes from those two sources to any other entry are dropped, so the remaining entries can be loaded only from the zero constant or the arithmetic result.

Every port is a plain control or data pin. Nothing flows as a stream here, so there is no valid/ready handshake and no back-pressure.

Top module: `mask_regfile`

## Requirements
- R1: A synchronous active-high `rst` clears every entry to zero on the next clock edge.
- R2: Source select `src_sel` encodes 0 as all zeros, 1 as `imm_data`, 2 as `alu_data` and 3 as `mem_data`. The value written is the one this encoding picks.
- R3: On a clock edge, entry i loads the write bus when bit i of `wr_mask` is set and the write is allowed.
- R4: An entry whose mask bit is clear keeps its value across the edge.
- R5: When several mask bits are set, every selected entry captures the same bus value on the same edge.
- R6: When `src_sel` is 1 or 3, only entry 0 may load. Mask bits 1 to 7 are ignored for those sources, and those entries keep their values.
- R7: `rd_data` is combinational. It equals entry `rd_idx` (bits 2:0 of the index, binary). It shows a write on the cycle after the write edge.
- R8: The data width is set by parameter `DW`, with a default of 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_mask | input | 8 | One-hot (or multi-hot) write mask, bit i selects entry i |
| src_sel | input | 2 | Write source: 0 zero, 1 immediate, 2 ALU, 3 memory |
| imm_data | input | DW | Immediate data from the controller |
| alu_data | input | DW | Arithmetic unit result |
| mem_data | input | DW | Data memory read data |
| rd_idx | input | 3 | Binary read index |
| rd_data | output | DW | Selected entry contents |

## Verification
The bench builds the block with the default `DW` of 8. Full-width values such as 0xFF and 0x80 are then reachable, which exposes any truncation in the source selector or the hold path. Random masks with many bits set, mixed with the restricted sources 1 and 3, reach the case where entry 0 loads while the other entries stay put in the same cycle.

// File: rtl/mask_regfile_pkg.sv
package mask_regfile_pkg;
  localparam int unsigned NREG = 8;
  localparam int unsigned IDXW = $clog2(NREG);
  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_IMM  = 2'd1,
    SRC_ALU  = 2'd2,
    SRC_MEM  = 2'd3
  } wr_src_e;
endpackage

// File: rtl/mrf_src_mux.sv
module mrf_src_mux
  import mask_regfile_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  wr_src_e       sel,
  input  logic [DW-1:0] imm_d,
  input  logic [DW-1:0] alu_d,
  input  logic [DW-1:0] mem_d,
  output logic [DW-1:0] bus_o
);
  always_comb begin
    unique case (sel)
      SRC_ZERO: bus_o = '0;
      SRC_IMM:  bus_o = imm_d;
      SRC_ALU:  bus_o = alu_d;
      SRC_MEM:  bus_o = mem_d;
      default:  bus_o = '0;
    endcase
  end
endmodule

// File: rtl/mrf_mask_gate.sv
module mrf_mask_gate
  import mask_regfile_pkg::*;
(
  input  logic [NREG-1:0] mask_i,
  input  wr_src_e         sel,
  output logic [NREG-1:0] en_o
);
  logic direct_src;
  assign direct_src = (sel == SRC_IMM) || (sel == SRC_MEM);
  assign en_o[0] = mask_i[0];
  generate
    for (genvar g = 1; g < NREG; g++) begin : g_gate
      assign en_o[g] = mask_i[g] & ~direct_src;
    end
  endgenerate
endmodule

// File: rtl/mrf_entry.sv
module mrf_entry #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/mask_regfile.sv
module mask_regfile
  import mask_regfile_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREG-1:0] wr_mask,
  input  logic [1:0]      src_sel,
  input  logic [DW-1:0]   imm_data,
  input  logic [DW-1:0]   alu_data,
  input  logic [DW-1:0]   mem_data,
  input  logic [IDXW-1:0] rd_idx,
  output logic [DW-1:0]   rd_data
);
  wr_src_e              sel;
  logic [DW-1:0]        wbus;
  logic [NREG-1:0]      wen;
  logic [NREG-1:0][DW-1:0] regs;

  assign sel = wr_src_e'(src_sel);

  mrf_src_mux #(.DW(DW)) u_mux (
    .sel(sel), .imm_d(imm_data), .alu_d(alu_data), .mem_d(mem_data), .bus_o(wbus)
  );

  mrf_mask_gate u_gate (.mask_i(wr_mask), .sel(sel), .en_o(wen));

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      mrf_entry #(.DW(DW)) u_ent (
        .clk(clk), .rst(rst), .en(wen[g]), .d(wbus), .q(regs[g])
      );
    end
  endgenerate

  assign rd_data = regs[rd_idx];
endmodule

// File: rtl/mask_regfile_chk.sv
module mask_regfile_chk
  import mask_regfile_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [NREG-1:0] wr_mask,
  input logic [1:0]      src_sel,
  input logic [DW-1:0]   imm_data,
  input logic [DW-1:0]   alu_data,
  input logic [DW-1:0]   mem_data,
  input logic [IDXW-1:0] rd_idx,
  input logic [DW-1:0]   rd_data,
  input logic [NREG-1:0][DW-1:0] regs,
  input logic [DW-1:0]   wbus
);
  logic seen_edge;
  always_ff @(posedge clk) seen_edge <= 1'b1;

  // R1
  reset_clear_chk: assert property (@(posedge clk) seen_edge && rst |=> regs == '0);

  // R4
  hold_entry0_chk: assert property (@(posedge clk) disable iff (rst)
    seen_edge && !wr_mask[0] |=> $stable(regs[0]));

  // R3
  load_entry0_chk: assert property (@(posedge clk) disable iff (rst)
    seen_edge && wr_mask[0] |=> regs[0] == $past(wbus));

  // R6
  direct_block_chk: assert property (@(posedge clk) disable iff (rst)
    seen_edge && src_sel[0] |=> regs[7:1] == $past(regs[7:1]));

  // R2
  zero_src_chk: assert property (@(posedge clk) disable iff (rst)
    seen_edge && src_sel == 2'd0 && wr_mask[0] |=> regs[0] == '0);

  // R7
  read_port_chk: assert property (@(posedge clk) disable iff (rst)
    seen_edge |-> rd_data == regs[rd_idx]);
endmodule

bind mask_regfile mask_regfile_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .wr_mask(wr_mask), .src_sel(src_sel),
  .imm_data(imm_data), .alu_data(alu_data), .mem_data(mem_data),
  .rd_idx(rd_idx), .rd_data(rd_data), .regs(regs), .wbus(wbus)
);

// File: tb/sim_mask_regfile.sv
module sim_mask_regfile;
  localparam int unsigned DW = 8;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst;
  logic [7:0] wr_mask;
  logic [1:0] src_sel;
  logic [DW-1:0] imm_data, alu_data, mem_data;
  logic [2:0] rd_idx;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [8];
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mask_regfile #(.DW(DW)) u0 (
    .clk(clk), .rst(rst), .wr_mask(wr_mask), .src_sel(src_sel),
    .imm_data(imm_data), .alu_data(alu_data), .mem_data(mem_data),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  function automatic logic [DW-1:0] pick(input logic [1:0] s, input logic [DW-1:0] i,
                                          input logic [DW-1:0] a, input logic [DW-1:0] m);
    case (s)
      2'd0: return '0;
      2'd1: return i;
      2'd2: return a;
      default: return m;
    endcase
  endfunction

  function automatic logic allowed(input int r, input logic [1:0] s);
    return (r == 0) || (s == 2'd0) || (s == 2'd2);
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, apply the edge, update model
  task automatic wr(input logic [7:0] m, input logic [1:0] s, input logic [DW-1:0] i,
                    input logic [DW-1:0] a, input logic [DW-1:0] me);
    logic [DW-1:0] v;
    @(negedge clk);
    wr_mask = m; src_sel = s; imm_data = i; alu_data = a; mem_data = me;
    v = pick(s, i, a, me);
    @(posedge clk);
    for (int r = 0; r < 8; r++) if (m[r] && allowed(r, s)) model[r] = v;
    @(negedge clk);
    wr_mask = '0;
  endtask

  task automatic read_all(input string req);
    for (int r = 0; r < 8; r++) begin
      rd_idx = 3'(r);
      #1;
      check(req, rd_data, model[r]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; wr_mask = '0; src_sel = '0; imm_data = '0; alu_data = '0; mem_data = '0; rd_idx = '0;
    for (int r = 0; r < 8; r++) model[r] = '0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    read_all("R1");

    // R3 R2: ALU source loads each entry individually
    for (int r = 0; r < 8; r++) wr(8'(1 << r), 2'd2, 8'h11, 8'(8'hA0 + r), 8'h22);
    read_all("R3");
    // R7: visible the cycle after the edge
    @(negedge clk); wr_mask = 8'h08; src_sel = 2'd2; alu_data = 8'h5C; rd_idx = 3'd3;
    #1; check("R7", rd_data, model[3]);
    @(posedge clk); model[3] = 8'h5C;
    @(negedge clk); wr_mask = '0; check("R7", rd_data, 8'h5C);
    // R5: multi-hot, full-width value
    wr(8'hFE, 2'd2, 8'h00, 8'hFF, 8'h00);
    read_all("R5");
    // R2 zero source on several entries
    wr(8'h6A, 2'd0, 8'h33, 8'h44, 8'h55);
    read_all("R2");
    // R6: immediate and memory only reach entry 0
    wr(8'hFF, 2'd1, 8'h80, 8'h01, 8'h02);
    read_all("R6");
    wr(8'hFF, 2'd3, 8'h03, 8'h04, 8'h7E);
    read_all("R6");
    // R4: empty mask changes nothing
    wr(8'h00, 2'd2, 8'h00, 8'h99, 8'h00);
    read_all("R4");
    // R8 width: 0x80 survives whole
    wr(8'h01, 2'd2, 8'h00, 8'h80, 8'h00);
    rd_idx = 3'd0; #1; check("R8", rd_data, 8'h80);

    // random mix
    for (int k = 0; k < 300; k++) begin
      wr(8'($urandom), 2'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
      rd_idx = 3'($urandom); #1;
      check("R3/R4/R6 random", rd_data, model[rd_idx]);
    end
    read_all("R5 random final");

    // R1 reset clears everything
    @(negedge clk); rst = 1'b1;
    @(posedge clk); for (int r = 0; r < 8; r++) model[r] = '0;
    @(negedge clk); rst = 1'b0;
    read_all("R1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule